// File: doc/BRIEF.md
# Correlation-Gated Sub-Pixel Interpolation Filter

This block computes three 8-tap luma interpolation results per accepted input window. The window holds eight neighbouring integer samples. The three filters are a quarter-position filter, a half-position filter and a three-quarter-position filter, and all three read the same window. Software configures nothing: a per-window mode input selects how much effort the block spends on detecting redundant work.

Before a window reaches a filter, a comparison stage checks whether every tap that carries a non-zero weight holds the same value. In exact mode the samples are compared at full width. In the similarity modes the low 1 to 4 bits are dropped before comparing. If a filter's taps match, the filter is skipped:

- its tap registers keep their previous contents, so its adder tree does not toggle;
- the result is replaced by the sample under the filter's heaviest tap, scaled to the output format.

Because every filter's weights sum to 64, exact-mode skipping never changes a result. Similarity-mode skipping trades a small error for fewer active filters.

Results, per-filter skip flags and a valid strobe appear one clock after the window is accepted.

Top module: `interp_gated_fir`

## Requirements
- R1: After reset, out_valid is 0, all three results are 0 and out_skip is 0. out_valid is high exactly in the cycle after a cycle in which in_valid was high.
- R2: With sample i taken from in_samples[8i+7:8i], each result is the weighted sum of the eight samples, right-shifted by (SAMPLE_W-8). The weights are:
  - out_res_a: -1,4,-10,58,17,-5,1,0
  - out_res_b: -1,4,-11,40,40,-11,4,-1
  - out_res_c: 0,1,-5,17,58,-10,4,-1
- R3: in_mode values 0, 6 and 7 disable gating: no filter is skipped, and every result follows R2.
- R4: in_mode 1 (exact) skips a filter when all of its non-zero-weight taps are identical at full width. These taps are 0..6 for A, 0..7 for B and 1..7 for C. A skipped result is 64 times the dominant sample (sample 3 for A and B, sample 4 for C), shifted as in R2, which equals the computed result. A skipped filter's tap registers are left unchanged.
- R5: in_mode 2, 3, 4 and 5 apply the R4 comparison after dropping in_mode-1 low bits from each sample. A skipped filter outputs 64 times its dominant sample even where that differs from the weighted sum.
- R6: out_skip reports, with the result, which filters were skipped for the window: bit 0 for A, bit 1 for B, bit 2 for C.
- R7: In a cycle after in_valid was low, the results and out_skip keep the values they had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The window and mode are accepted this cycle |
| in_mode | input | 3 | Gating mode: 0 off, 1 exact, 2..5 similarity with mode-1 bits dropped |
| in_samples | input | 8*SAMPLE_W | Eight samples; sample i at bits [i*SAMPLE_W +: SAMPLE_W] |
| out_valid | output | 1 | Results belong to the previous cycle's window |
| out_res_a | output | SAMPLE_W+8 | Signed result of filter A |
| out_res_b | output | SAMPLE_W+8 | Signed result of filter B |
| out_res_c | output | SAMPLE_W+8 | Signed result of filter C |
| out_skip | output | 3 | Per-filter skip flags for the current results |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- that mode 0 never produces a skip flag;
- that a skipped filter's computed sum stays frozen;
- that idle cycles leave the outputs untouched.

Arithmetic correctness needs the bench's scenarios. These are:
- random windows;
- windows that are flat over exactly one filter's span;
- windows that differ only below, or just above, the truncation boundary.

Each is compared cycle by cycle against an independent weighted-sum model. Only those scenarios show that exact-mode bypass values match the computed sums, and that similarity mode substitutes the dominant sample.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int NTAP   = 8;
  localparam int NFILT  = 3;
  localparam int MODE_W = 3;
  localparam int WSUM_LOG2 = 6;  // every filter's weights sum to 64

  typedef enum logic [1:0] {FILT_A = 2'd0, FILT_B = 2'd1, FILT_C = 2'd2} filt_e;

  function automatic int coef_quarter(int idx);
    case (idx)
      0: return -1;
      1: return 4;
      2: return -10;
      3: return 58;
      4: return 17;
      5: return -5;
      6: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int coef_half(int idx);
    case (idx)
      0, 7: return -1;
      1, 6: return 4;
      2, 5: return -11;
      default: return 40;
    endcase
  endfunction

  function automatic int tap_coef(filt_e ft, int idx);
    case (ft)
      FILT_A:  return coef_quarter(idx);
      FILT_B:  return coef_half(idx);
      default: return coef_quarter(NTAP - 1 - idx);
    endcase
  endfunction

  // First tap holding the largest weight (lower index wins on a tie)
  function automatic int dom_tap(filt_e ft);
    int best;
    best = 0;
    for (int i = 1; i < NTAP; i++)
      if (tap_coef(ft, i) > tap_coef(ft, best)) best = i;
    return best;
  endfunction

  // Number of low bits to drop, or -1 when gating is off
  function automatic int trunc_bits(logic [MODE_W-1:0] mode, int max_trunc);
    int m;
    m = int'(mode);
    if (m == 1) return 0;
    if (m >= 2 && m <= max_trunc + 1) return m - 1;
    return -1;
  endfunction
endpackage

// File: rtl/interp_tap_compare.sv
module interp_tap_compare
  import interp_pkg::*;
#(
  parameter int    SAMPLE_W  = 8,
  parameter filt_e FT        = FILT_A,
  parameter int    MAX_TRUNC = 4
) (
  input  logic [NTAP*SAMPLE_W-1:0] samples,
  input  logic [MODE_W-1:0]        mode,
  output logic                     skip
);
  localparam int DOM = dom_tap(FT);

  always_comb begin
    int t;
    int tt;
    logic match;
    logic [SAMPLE_W-1:0] ref_v;
    t = trunc_bits(mode, MAX_TRUNC);
    tt = (t < 0) ? 0 : t;
    ref_v = samples[DOM*SAMPLE_W +: SAMPLE_W] >> tt;
    match = 1'b1;
    for (int i = 0; i < NTAP; i++) begin
      if (tap_coef(FT, i) != 0 &&
          ((samples[i*SAMPLE_W +: SAMPLE_W] >> tt) != ref_v))
        match = 1'b0;
    end
    skip = (t >= 0) && match;
  end
endmodule

// File: rtl/interp_fir8.sv
module interp_fir8
  import interp_pkg::*;
#(
  parameter int    SAMPLE_W = 8,
  parameter filt_e FT       = FILT_A,
  parameter int    OUT_W    = 16,
  parameter int    SHIFT    = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NTAP*SAMPLE_W-1:0] samples,
  output logic signed [OUT_W-1:0]  sum
);
  logic [NTAP*SAMPLE_W-1:0] taps_q;

  always_ff @(posedge clk) begin
    if (rst)
      taps_q <= '0;
    else if (load)
      taps_q <= samples;
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < NTAP; i++)
      acc = acc + tap_coef(FT, i) * int'(taps_q[i*SAMPLE_W +: SAMPLE_W]);
    sum = OUT_W'(acc >>> SHIFT);
  end
endmodule

// File: rtl/interp_gated_fir.sv
module interp_gated_fir
  import interp_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_TRUNC = 4,
  parameter int GUARD_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [MODE_W-1:0]                 in_mode,
  input  logic [NTAP*SAMPLE_W-1:0]          in_samples,
  output logic                              out_valid,
  output logic signed [SAMPLE_W+GUARD_W-1:0] out_res_a,
  output logic signed [SAMPLE_W+GUARD_W-1:0] out_res_b,
  output logic signed [SAMPLE_W+GUARD_W-1:0] out_res_c,
  output logic [NFILT-1:0]                  out_skip
);
  localparam int OUT_W = SAMPLE_W + GUARD_W;
  localparam int SHIFT = SAMPLE_W - 8;

  logic signed [OUT_W-1:0] sum_w [NFILT];
  logic signed [OUT_W-1:0] res_w [NFILT];
  logic [SAMPLE_W-1:0]     dom_q [NFILT];
  logic [NFILT-1:0]        skip_w;
  logic [NFILT-1:0]        skip_q;
  logic                    valid_q;

  for (genvar gi = 0; gi < NFILT; gi++) begin : g_filt
    localparam filt_e FT  = filt_e'(gi);
    localparam int    DOM = dom_tap(FT);

    interp_tap_compare #(
      .SAMPLE_W (SAMPLE_W),
      .FT       (FT),
      .MAX_TRUNC(MAX_TRUNC)
    ) u_cmp (
      .samples(in_samples),
      .mode   (in_mode),
      .skip   (skip_w[gi])
    );

    interp_fir8 #(
      .SAMPLE_W(SAMPLE_W),
      .FT      (FT),
      .OUT_W   (OUT_W),
      .SHIFT   (SHIFT)
    ) u_fir (
      .clk    (clk),
      .rst    (rst),
      .load   (in_valid && !skip_w[gi]),
      .samples(in_samples),
      .sum    (sum_w[gi])
    );

    always_ff @(posedge clk) begin
      if (rst)
        dom_q[gi] <= '0;
      else if (in_valid)
        dom_q[gi] <= in_samples[DOM*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
      int byp;
      byp = (int'(dom_q[gi]) <<< WSUM_LOG2) >>> SHIFT;
      res_w[gi] = skip_q[gi] ? OUT_W'(byp) : sum_w[gi];
    end

    AST_SKIP_FREEZES_SUM: assert property (@(posedge clk) disable iff (rst)
      (in_valid && skip_w[gi]) |=> $stable(sum_w[gi])); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      skip_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) skip_q <= skip_w;
    end
  end

  assign out_valid = valid_q;
  assign out_res_a = res_w[0];
  assign out_res_b = res_w[1];
  assign out_res_c = res_w[2];
  assign out_skip  = skip_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_OFF_NEVER_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == '0) |=> (out_skip == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_res_a) && $stable(out_res_b) &&
                   $stable(out_res_c) && $stable(out_skip))); // R7
endmodule

// File: tb/interp_gated_fir_test.sv
module interp_gated_fir_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = 3'd0;
  logic [63:0] in_samples = '0;
  logic        out_valid;
  logic signed [15:0] out_res_a, out_res_b, out_res_c;
  logic [2:0]  out_skip;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic chk_en = 1'b0;

  logic               exp_valid;
  logic signed [15:0] exp_a, exp_b, exp_c;
  logic [2:0]         exp_skip;
  string              tag_res, tag_skip;

  always #10 clk = ~clk;

  interp_gated_fir uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_samples(in_samples), .out_valid(out_valid), .out_res_a(out_res_a),
    .out_res_b(out_res_b), .out_res_c(out_res_c), .out_skip(out_skip)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic ref_eval(input int ft, input logic [63:0] w, input logic [2:0] md,
                          output logic sk, output logic signed [15:0] val);
    int c[8];
    int s[8];
    int dom, t, acc;
    if (ft == 0)      c = '{-1, 4, -10, 58, 17, -5, 1, 0};
    else if (ft == 1) c = '{-1, 4, -11, 40, 40, -11, 4, -1};
    else              c = '{0, 1, -5, 17, 58, -10, 4, -1};
    for (int i = 0; i < 8; i++) s[i] = int'(w[8*i +: 8]);
    dom = 0;
    for (int i = 1; i < 8; i++) if (c[i] > c[dom]) dom = i;
    if (md == 3'd1) t = 0;
    else if (md >= 3'd2 && md <= 3'd5) t = int'(md) - 1;
    else t = -1;
    sk = (t >= 0);
    if (t >= 0)
      for (int i = 0; i < 8; i++)
        if (c[i] != 0 && (s[i] >> t) != (s[dom] >> t)) sk = 1'b0;
    acc = 0;
    for (int i = 0; i < 8; i++) acc += c[i] * s[i];
    val = 16'(sk ? s[dom] * 64 : acc);
  endtask

  logic sa, sb, sc;
  logic signed [15:0] va, vb, vc;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_valid <= 1'b0; exp_a <= '0; exp_b <= '0; exp_c <= '0; exp_skip <= '0;
      tag_res <= "R1"; tag_skip <= "R1";
    end else if (in_valid) begin
      ref_eval(0, in_samples, in_mode, sa, va);
      ref_eval(1, in_samples, in_mode, sb, vb);
      ref_eval(2, in_samples, in_mode, sc, vc);
      exp_valid <= 1'b1;
      exp_a <= va; exp_b <= vb; exp_c <= vc;
      exp_skip <= {sc, sb, sa};
      if (in_mode == 3'd1) begin tag_res <= "R4"; tag_skip <= "R6"; end
      else if (in_mode >= 3'd2 && in_mode <= 3'd5) begin tag_res <= "R5"; tag_skip <= "R6"; end
      else begin tag_res <= "R2"; tag_skip <= "R3"; end
    end else begin
      exp_valid <= 1'b0;
      tag_res <= "R7"; tag_skip <= "R7";
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R1 valid", int'(out_valid), int'(exp_valid));
      chk({tag_res, " res_a"}, int'(out_res_a), int'(exp_a));
      chk({tag_res, " res_b"}, int'(out_res_b), int'(exp_b));
      chk({tag_res, " res_c"}, int'(out_res_c), int'(exp_c));
      chk({tag_skip, " skip"}, int'(out_skip), int'(exp_skip));
    end
  end

  function automatic logic [63:0] gen(int kind);
    logic [63:0] w;
    logic [7:0] v, m;
    int k;
    v = 8'($urandom);
    for (int i = 0; i < 8; i++) w[8*i +: 8] = 8'($urandom);
    case (kind)
      1: for (int i = 0; i < 8; i++) w[8*i +: 8] = v;
      2: begin for (int i = 0; i < 7; i++) w[8*i +: 8] = v; w[63:56] = v ^ 8'h80; end
      3: begin for (int i = 1; i < 8; i++) w[8*i +: 8] = v; w[7:0] = v ^ 8'h40; end
      4: begin
        k = int'($urandom % 5);
        m = 8'((1 << k) - 1);
        for (int i = 0; i < 8; i++) w[8*i +: 8] = (v & ~m) | (8'($urandom) & m);
      end
      5: begin
        k = int'($urandom % 4);
        for (int i = 0; i < 8; i++) w[8*i +: 8] = v;
        w[8*5 +: 8] = v ^ 8'(1 << k);
      end
      default: ;
    endcase
    return w;
  endfunction

  task automatic drive(logic vld, logic [2:0] md, logic [63:0] w);
    @(negedge clk);
    in_valid = vld; in_mode = md; in_samples = w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset res_a", int'(out_res_a), 0);
    chk("R1 reset res_b", int'(out_res_b), 0);
    chk("R1 reset res_c", int'(out_res_c), 0);
    chk("R1 reset skip", int'(out_skip), 0);
    rst = 1'b0;
    chk_en = 1'b1;
    drive(1'b1, 3'd1, {8{8'd200}});
    drive(1'b1, 3'd0, {8{8'd200}});
    drive(1'b1, 3'd1, {8'd0, {7{8'd90}}});
    drive(1'b1, 3'd1, {{7{8'd33}}, 8'd255});
    drive(1'b1, 3'd4, 64'hCFCECDCCCBCAC9C8);
    drive(1'b1, 3'd2, 64'hCFCECDCCCBCAC9C8);
    drive(1'b0, 3'd0, '0);
    drive(1'b0, 3'd1, {8{8'd7}});
    drive(1'b1, 3'd7, {8{8'd255}});
    drive(1'b1, 3'd5, {8{8'd255}});
    for (int n = 0; n < 3000; n++)
      drive(($urandom % 4) != 0, 3'($urandom % 8), gen(int'($urandom % 6)));
    drive(1'b0, 3'd0, '0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule